// File: doc/BRIEF.md
# Width-Upsizing FIFO with Optional Clock Crossing

This block takes narrow words from a producer, one per valid/ready handshake, and hands wide words to a consumer. Each wide word is assembled from `RATIO` narrow words accepted in a row. The word that arrived first sits in the lowest slice. Only complete wide words enter storage, so the consumer never sees a half-built group. Storage holds `2**DEPTH_LOG2` wide words.

The `CLK_MODE` parameter picks how the two sides are clocked. In the common-clock variant, each side reads the other's binary pointer directly. In the split-clock variant, each pointer is registered in Gray code in its home domain and then crosses through a two-flop synchroniser into the other domain. Each side has its own active-high asynchronous reset, and both resets are expected to be held for several cycles of their own clocks.

Top module: `upsize_fifo`

## Requirements
- R1: While a side's reset is asserted and in the first cycle after it is released, `out_valid` is 0. `in_ready` is 1 once the write reset is released.
- R2: The k-th narrow word accepted in a group (k counted from 0) appears in bits [k*WORD_W +: WORD_W] of the wide word built from that group.
- R3: `out_valid` stays low until all `RATIO` words of a group have been accepted. A partial group is never presented.
- R4: `in_ready` is low exactly when `RATIO-1` words of the current group are already held and storage contains `2**DEPTH_LOG2` wide words. A word offered while `in_ready` is low is not taken.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R6: Wide words leave in the order their groups completed. `out_valid` is high exactly when storage is not empty. Nothing is removed while `out_valid` is low.
- R7: With `CLK_MODE = CLK_SPLIT` and unrelated clocks, every wide word arrives intact and in order. The FIFO fills until the producer stalls, then drains to empty once the consumer reads again. The write pointer advances by at most one per write clock.
- R8: Storage never holds more than `2**DEPTH_LOG2` wide words. Starting from empty with no partial group held, the producer stalls after exactly `2**DEPTH_LOG2 * RATIO + RATIO - 1` words.
- R9: With `CLK_MODE = CLK_COMMON`, a wide word is visible on `out_valid` in the cycle after the edge that accepted its last narrow word. A word removed at an edge frees its slot for the writer in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Write-side asynchronous reset, active high |
| in_data | input | WORD_W | Narrow input word |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | FIFO can take a narrow word |
| rd_clk | input | 1 | Read-side clock (tie to `wr_clk` in common-clock mode) |
| rd_rst | input | 1 | Read-side asynchronous reset, active high |
| out_data | output | WORD_W*RATIO | Packed wide word, first arrival in the low slice |
| out_valid | output | 1 | A wide word is available |
| out_ready | input | 1 | Consumer takes the wide word |

## Verification
The common-clock instance runs through four patterns, each compared every cycle against a behavioural queue model:
- Random valid and ready on both sides mixes every slot position with pushes and pops in the same cycle, which exposes errors in packing order and in the next-cycle visibility of a completed group.
- A drain followed by write-only traffic checks the exact stall point and that the refused last word is lost nowhere.
- A read-only burst shows that the FIFO empties cleanly.
- Full-rate traffic on both sides shows that storage is never starved or overfilled.

The split-clock instance uses write and read periods with no common ratio. It is filled to the stall, then drained with random ready, which separates a correct Gray crossing from one that drops or repeats wide words.

// File: rtl/upsize_fifo_pkg.sv
package upsize_fifo_pkg;

  // Selects how the write and read sides are clocked.
  typedef enum logic {
    CLK_COMMON = 1'b0,
    CLK_SPLIT  = 1'b1
  } clk_mode_e;

endpackage

// File: rtl/upsize_fifo_packer.sv
// Collects RATIO narrow words; the last one completes the group and is
// written to storage together with the held slices in the same cycle.
module upsize_fifo_packer #(
  parameter int WORD_W = 8,
  parameter int RATIO  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [WORD_W-1:0]        in_data,
  input  logic                     in_valid,
  input  logic                     full,
  output logic                     in_ready,
  output logic                     push,
  output logic [WORD_W*RATIO-1:0]  push_data
);

  localparam int SW     = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam int HOLD_W = WORD_W * (RATIO - 1);
  localparam logic [SW-1:0] LAST_SLOT = SW'(RATIO - 1);

  logic [SW-1:0]     slot, slot_nxt;
  logic [HOLD_W-1:0] held;
  logic              last, take, hold_en;

  assign last     = (slot == LAST_SLOT);
  assign in_ready = !(last && full);
  assign take     = in_valid && in_ready;
  assign push     = take && last;
  assign hold_en  = take && !last;

  always_comb begin
    slot_nxt = slot;
    if (take) slot_nxt = last ? '0 : slot + SW'(1);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) slot <= '0;
    else     slot <= slot_nxt;
  end

  // Held slices carry no reset: they are only read after being written.
  always_ff @(posedge clk) begin
    for (int k = 0; k < RATIO - 1; k++) begin
      if (hold_en && (slot == SW'(k))) held[k*WORD_W +: WORD_W] <= in_data;
    end
  end

  assign push_data = {in_data, held};

endmodule

// File: rtl/upsize_fifo_ptr_sync.sv
// Moves a binary pointer into another clock domain: Gray register at the
// source, two flops at the destination, conversion back to binary.
module upsize_fifo_ptr_sync #(
  parameter int AW = 3
) (
  input  logic          src_clk,
  input  logic          src_rst,
  input  logic [AW-1:0] src_bin,
  input  logic          dst_clk,
  input  logic          dst_rst,
  output logic [AW-1:0] dst_bin
);

  logic [AW-1:0] gray_nxt, src_gray, meta, settled;

  assign gray_nxt = src_bin ^ (src_bin >> 1);

  always_ff @(posedge src_clk or posedge src_rst) begin
    if (src_rst) src_gray <= '0;
    else         src_gray <= gray_nxt;
  end

  always_ff @(posedge dst_clk or posedge dst_rst) begin
    if (dst_rst) begin
      meta    <= '0;
      settled <= '0;
    end else begin
      meta    <= src_gray;
      settled <= meta;
    end
  end

  for (genvar i = 0; i < AW; i++) begin : g_bin
    assign dst_bin[i] = ^settled[AW-1:i];
  end

endmodule

// File: rtl/upsize_fifo_store.sv
// Wide-word storage: registered write, combinational read.
module upsize_fifo_store #(
  parameter int DW    = 32,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);

  localparam int N = 1 << IDX_W;

  logic [DW-1:0] cells [N];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/upsize_fifo.sv
module upsize_fifo
  import upsize_fifo_pkg::*;
#(
  parameter int        WORD_W     = 8,
  parameter int        RATIO      = 4,
  parameter int        DEPTH_LOG2 = 2,
  parameter clk_mode_e CLK_MODE   = CLK_COMMON
) (
  input  logic                     wr_clk,
  input  logic                     wr_rst,
  input  logic [WORD_W-1:0]        in_data,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     rd_clk,
  input  logic                     rd_rst,
  output logic [WORD_W*RATIO-1:0]  out_data,
  output logic                     out_valid,
  input  logic                     out_ready
);

  localparam int OUT_W = WORD_W * RATIO;
  localparam int AW    = DEPTH_LOG2 + 1;
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [AW-1:0]    w_ptr, w_ptr_nxt, r_ptr, r_ptr_nxt;
  logic [AW-1:0]    r_ptr_w, w_ptr_r;
  logic             full, push, pop;
  logic [OUT_W-1:0] push_data;

  // ---------------- write side ----------------
  assign full = ((w_ptr - r_ptr_w) == AW'(DEPTH));

  upsize_fifo_packer #(.WORD_W(WORD_W), .RATIO(RATIO)) u_pack (
    .clk       (wr_clk),
    .rst       (wr_rst),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .full      (full),
    .in_ready  (in_ready),
    .push      (push),
    .push_data (push_data)
  );

  always_comb begin
    w_ptr_nxt = w_ptr;
    if (push) w_ptr_nxt = w_ptr + AW'(1);
  end

  always_ff @(posedge wr_clk or posedge wr_rst) begin
    if (wr_rst) w_ptr <= '0;
    else        w_ptr <= w_ptr_nxt;
  end

  // ---------------- read side ----------------
  assign out_valid = (r_ptr != w_ptr_r);
  assign pop       = out_valid && out_ready;

  always_comb begin
    r_ptr_nxt = r_ptr;
    if (pop) r_ptr_nxt = r_ptr + AW'(1);
  end

  always_ff @(posedge rd_clk or posedge rd_rst) begin
    if (rd_rst) r_ptr <= '0;
    else        r_ptr <= r_ptr_nxt;
  end

  // ---------------- pointer exchange ----------------
  if (CLK_MODE == CLK_SPLIT) begin : g_split
    upsize_fifo_ptr_sync #(.AW(AW)) u_w2r (
      .src_clk (wr_clk), .src_rst (wr_rst), .src_bin (w_ptr),
      .dst_clk (rd_clk), .dst_rst (rd_rst), .dst_bin (w_ptr_r)
    );
    upsize_fifo_ptr_sync #(.AW(AW)) u_r2w (
      .src_clk (rd_clk), .src_rst (rd_rst), .src_bin (r_ptr),
      .dst_clk (wr_clk), .dst_rst (wr_rst), .dst_bin (r_ptr_w)
    );
  end else begin : g_common
    assign w_ptr_r = w_ptr;
    assign r_ptr_w = r_ptr;
  end

  // ---------------- storage ----------------
  upsize_fifo_store #(.DW(OUT_W), .IDX_W(DEPTH_LOG2)) u_store (
    .clk   (wr_clk),
    .we    (push),
    .waddr (w_ptr[AW-2:0]),
    .wdata (push_data),
    .raddr (r_ptr[AW-2:0]),
    .rdata (out_data)
  );

endmodule

// File: rtl/upsize_fifo_chk.sv
module upsize_fifo_chk #(
  parameter int AW    = 3,
  parameter int OUT_W = 32,
  parameter int DEPTH = 4
) (
  input logic             wr_clk,
  input logic             wr_rst,
  input logic             rd_clk,
  input logic             rd_rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic [AW-1:0]    w_ptr,
  input logic [AW-1:0]    r_ptr,
  input logic [AW-1:0]    r_ptr_w
);

  logic [AW-1:0] occ;
  assign occ = w_ptr - r_ptr_w;

  assert_empty_after_reset_R1: assert property (
    @(posedge rd_clk) rd_rst |=> !out_valid);

  assert_hold_stable_R5: assert property (
    @(posedge rd_clk) disable iff (rd_rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_refused_word_R4: assert property (
    @(posedge wr_clk) disable iff (wr_rst)
    (in_valid && !in_ready) |=> $stable(w_ptr));

  assert_no_pop_empty_R6: assert property (
    @(posedge rd_clk) disable iff (rd_rst)
    !out_valid |=> $stable(r_ptr));

  assert_no_overflow_R8: assert property (
    @(posedge wr_clk) disable iff (wr_rst)
    occ <= AW'(DEPTH));

  assert_wptr_step_R7: assert property (
    @(posedge wr_clk) disable iff (wr_rst)
    (w_ptr == $past(w_ptr)) || (w_ptr == $past(w_ptr) + AW'(1)));

endmodule

bind upsize_fifo upsize_fifo_chk #(
  .AW    (AW),
  .OUT_W (OUT_W),
  .DEPTH (DEPTH)
) u_chk (
  .wr_clk    (wr_clk),
  .wr_rst    (wr_rst),
  .rd_clk    (rd_clk),
  .rd_rst    (rd_rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .w_ptr     (w_ptr),
  .r_ptr     (r_ptr),
  .r_ptr_w   (r_ptr_w)
);

// File: tb/upsize_fifo_bench.sv
module upsize_fifo_bench;
  import upsize_fifo_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int W     = 8;
  localparam int R     = 4;
  localparam int DL    = 2;
  localparam int DEPTH = 1 << DL;
  localparam int OW    = W * R;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [OW-1:0] act, input logic [OW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ================= common-clock instance =================
  logic          s_clk = 0;
  logic          s_rst;
  logic [W-1:0]  s_in_data;
  logic          s_in_valid, s_in_ready;
  logic [OW-1:0] s_out_data;
  logic          s_out_valid, s_out_ready;
  bit            s_done = 0;

  always #(CLK_PERIOD/2) s_clk = ~s_clk;

  upsize_fifo #(.WORD_W(W), .RATIO(R), .DEPTH_LOG2(DL), .CLK_MODE(CLK_COMMON)) u_upsize_fifo (
    .wr_clk (s_clk), .wr_rst (s_rst), .in_data (s_in_data),
    .in_valid (s_in_valid), .in_ready (s_in_ready),
    .rd_clk (s_clk), .rd_rst (s_rst), .out_data (s_out_data),
    .out_valid (s_out_valid), .out_ready (s_out_ready)
  );

  logic [OW-1:0] sq[$];
  logic [W-1:0]  s_hold [R];
  int            s_slot = 0;
  int            s_fill_cnt = 0;
  int            s_fill_exp = 0;

  initial begin
    s_rst = 1; s_in_valid = 0; s_out_ready = 0; s_in_data = '0;
    repeat (5) @(posedge s_clk);
    @(negedge s_clk);
    chk(s_out_valid === 1'b0, "R1 out_valid in reset", OW'(s_out_valid), '0);
    s_rst = 0;
    @(negedge s_clk);
    chk(s_in_ready === 1'b1, "R1 in_ready after reset", OW'(s_in_ready), OW'(1));
    chk(s_out_valid === 1'b0, "R1 out_valid after reset", OW'(s_out_valid), '0);
    for (int cyc = 0; cyc < 1200; cyc++) begin
      bit er, ev, v, r;
      logic [W-1:0]  d;
      logic [OW-1:0] p;
      if (cyc > 0) @(negedge s_clk);
      er = !((s_slot == R-1) && (sq.size() == DEPTH));
      ev = (sq.size() > 0);
      chk(s_in_ready === er, "R4 in_ready", OW'(s_in_ready), OW'(er));
      chk(s_out_valid === ev, "R3 R6 R9 out_valid", OW'(s_out_valid), OW'(ev));
      if (ev) chk(s_out_data === sq[0], "R2 R5 R6 out_data", s_out_data, sq[0]);
      if (cyc == 340) begin
        s_fill_cnt = 0;
        s_fill_exp = DEPTH*R + R - 1 - s_slot;
      end
      if (cyc == 499) begin
        chk(s_in_ready === 1'b0, "R4 stalled when full", OW'(s_in_ready), '0);
        chk(s_fill_cnt == s_fill_exp, "R8 words taken before stall",
            OW'(s_fill_cnt), OW'(s_fill_exp));
      end
      if (cyc < 300 || cyc >= 900) begin
        v = 1'($urandom % 2); r = 1'($urandom % 2);
      end else if (cyc < 340) begin
        v = 0; r = 1;
      end else if (cyc < 500) begin
        v = 1; r = 0;
      end else if (cyc < 700) begin
        v = 0; r = 1;
      end else begin
        v = 1; r = 1;
      end
      d = W'($urandom);
      s_in_valid = v; s_out_ready = r; s_in_data = d;
      if (cyc >= 340 && cyc < 500 && v && s_in_ready) s_fill_cnt++;
      if (r && ev) void'(sq.pop_front());
      if (v && er) begin
        if (s_slot == R-1) begin
          p[(R-1)*W +: W] = d;
          for (int k = 0; k < R-1; k++) p[k*W +: W] = s_hold[k];
          sq.push_back(p);
          s_slot = 0;
        end else begin
          s_hold[s_slot] = d;
          s_slot++;
        end
      end
    end
    s_in_valid = 0;
    s_done = 1;
  end

  // ================= split-clock instance =================
  logic          a_wclk = 0;
  logic          a_rclk = 0;
  logic          a_wrst, a_rrst;
  logic [W-1:0]  a_in_data;
  logic          a_in_valid, a_in_ready;
  logic [OW-1:0] a_out_data;
  logic          a_out_valid, a_out_ready;
  bit            a_fill_done = 0;
  bit            a_wdone = 0;
  bit            a_done = 0;
  logic [OW-1:0] aq[$];

  always #(CLK_PERIOD/2) a_wclk = ~a_wclk;
  always #(RD_PERIOD/2)  a_rclk = ~a_rclk;

  upsize_fifo #(.WORD_W(W), .RATIO(R), .DEPTH_LOG2(DL), .CLK_MODE(CLK_SPLIT)) u_upsize_fifo_split (
    .wr_clk (a_wclk), .wr_rst (a_wrst), .in_data (a_in_data),
    .in_valid (a_in_valid), .in_ready (a_in_ready),
    .rd_clk (a_rclk), .rd_rst (a_rrst), .out_data (a_out_data),
    .out_valid (a_out_valid), .out_ready (a_out_ready)
  );

  initial begin
    logic [W-1:0] hold [R];
    int slot, taken, stall, groups;
    slot = 0; taken = 0; stall = 0; groups = 0;
    a_wrst = 1; a_in_valid = 0; a_in_data = '0;
    repeat (6) @(posedge a_wclk);
    @(negedge a_wclk);
    a_wrst = 0;
    repeat (8) @(negedge a_wclk);
    while (stall < 30 || groups < 70) begin
      bit v;
      logic [W-1:0]  d;
      logic [OW-1:0] p;
      @(negedge a_wclk);
      if (!a_fill_done) v = 1;
      else v = 1'($urandom % 2);
      d = W'($urandom);
      a_in_valid = v; a_in_data = d;
      if (!a_fill_done) begin
        if (a_in_ready) stall = 0;
        else stall++;
        if (stall >= 30) begin
          chk(taken == DEPTH*R + R - 1, "R7 R8 split-clock fill count",
              OW'(taken), OW'(DEPTH*R + R - 1));
          a_fill_done = 1;
        end
      end
      if (v && a_in_ready) begin
        taken++;
        if (slot == R-1) begin
          p[(R-1)*W +: W] = d;
          for (int k = 0; k < R-1; k++) p[k*W +: W] = hold[k];
          aq.push_back(p);
          slot = 0;
          groups++;
        end else begin
          hold[slot] = d;
          slot++;
        end
      end
    end
    @(negedge a_wclk);
    a_in_valid = 0;
    a_wdone = 1;
  end

  initial begin
    a_rrst = 1; a_out_ready = 0;
    repeat (6) @(posedge a_rclk);
    @(negedge a_rclk);
    a_rrst = 0;
    @(negedge a_rclk);
    chk(a_out_valid === 1'b0, "R1 split out_valid after reset", OW'(a_out_valid), '0);
    wait (a_fill_done);
    while (!(a_wdone && aq.size() == 0)) begin
      bit r;
      @(negedge a_rclk);
      r = 1'($urandom % 2);
      a_out_ready = r;
      if (a_out_valid && aq.size() == 0)
        chk(1'b0, "R6 split out_valid with nothing stored", OW'(1), '0);
      if (r && a_out_valid && aq.size() > 0) begin
        chk(a_out_data === aq[0], "R7 R2 split-clock data", a_out_data, aq[0]);
        void'(aq.pop_front());
      end
    end
    @(negedge a_rclk);
    a_out_ready = 0;
    repeat (12) @(negedge a_rclk);
    chk(a_out_valid === 1'b0, "R7 empty after drain", OW'(a_out_valid), '0);
    a_done = 1;
  end

  // ================= finish and watchdog =================
  initial begin
    wait (s_done && a_done);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule